// File: doc/BRIEF.md
# Pulse-Triggered Exposure Timing Sequencer

This block sequences the exposure of a CCD sensor from an active-low trigger input while a free-running interlaced line counter keeps sync timing alive for a downstream frame grabber. While the trigger rests high, the sensor is held out of integration and every video line is black. Line and field timing keep running so the grabber never loses lock.

When the trigger falls, two short transfer-gate strobes flush the sensor, and integration then runs for as long as the trigger stays low. When the trigger returns high, one readout strobe is issued. In that same cycle the line counter is forced to line 6 of the odd field. The frame and line enables then open from line 20 to the end of that odd field and close again until the next exposure. A trigger that rises while the flush is still running is held until the flush finishes. It then starts the readout.

Top module: `exposure_sequencer`

## Requirements
- R1: The trigger passes through a two-flop synchroniser. A falling edge seen while the sequencer is idle raises `xfer_strb` in the third cycle after the input changes.
- R2: A flush consists of two `xfer_strb` pulses, each FLUSH_W cycles high, with exactly GAP_W low cycles between them.
- R3: `integ_on` is high in every cycle from the end of the second flush pulse up to the readout pulse, and in no other cycle. `xfer_strb` stays low while `integ_on` is high.
- R4: A rising trigger edge during integration raises `xfer_strb` for one readout pulse READ_W cycles wide, starting in the third cycle after the input changes. Exactly one readout occurs per trigger pulse. In the first readout cycle `line_no` equals RESTART_LINE (6), `pix_no` is 0 and `field_odd` is 1.
- R5: If the trigger rises before the flush completes, integration lasts exactly one cycle after the second flush pulse, and the readout pulse then follows.
- R6: `pix_no` counts 0 to LINE_CLKS-1 and `line_no` counts 1 to LINES (525). Both wrap and run freely whatever the trigger does. A readout restart is the only other change allowed.
- R7: `field_odd` is 1 for lines 1 to LINES/2 (262) and 0 for the remaining lines. It toggles at each field boundary.
- R8: After a readout, `frame_en` is high exactly for lines ACTIVE_START (20) to 262 of the odd field that follows. `line_en` equals `frame_en` with `pix_no` below H_ACTIVE. One uninterrupted field delivers (262-20+1)·H_ACTIVE `line_en` cycles.
- R9: `frame_en` and `line_en` stay low while idle and while integrating. `blank` is always the inverse of `line_en`.
- R10: A trigger fall during the delivered field closes the enables in the cycle the first flush pulse starts. They stay closed until the next readout.
- R11: During reset, `line_no`=1, `pix_no`=0, `field_odd`=1, the strobe, `integ_on` and both enables are 0, and `blank` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_n | input | 1 | Asynchronous active-low exposure trigger |
| xfer_strb | output | 1 | Transfer-gate strobe (flush and readout) |
| integ_on | output | 1 | Sensor integration window |
| line_no | output | $clog2(LINES+1) | Current line, 1-based |
| pix_no | output | $clog2(LINE_CLKS) | Clock position within the line |
| field_odd | output | 1 | 1 during the odd field |
| frame_en | output | 1 | Active-video frame enable |
| line_en | output | 1 | Active-video line enable |
| blank | output | 1 | Black-video flag |

## Verification
The bench shortens the line to 16 clocks with 12 active, and uses flush, gap and readout widths of 4, 3 and 5 cycles. It keeps the 525-line frame. A whole frame then takes 8400 cycles, so free-running wraps, a full delivered field, an integration longer than a frame and an aborted field all fit in one run. The narrow strobe widths let a two-cycle trigger pulse land inside the flush, which exercises the held readout. They also keep every strobe width and gap short enough to count exactly.

// File: rtl/expo_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the exposure sequencer.
package expo_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FLUSH_A,
        SQ_GAP,
        SQ_FLUSH_B,
        SQ_INTEG,
        SQ_READ
    } seq_state_t;
endpackage

// File: rtl/trig_sync.sv
`timescale 1ns/1ps
// trig_sync: brings the asynchronous active-low trigger into the clock
// domain through two flops and flags its falling edge.
// Assumes: the trigger idles high; reset values match that idle level.
module trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_n,
    output logic trig_lvl,
    output logic trig_fell
);
    logic s1_q, s2_q, prev_q;

    // Two-stage synchroniser plus one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= trig_n;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign trig_lvl  = s2_q;
    assign trig_fell = prev_q & ~s2_q;
endmodule

// File: rtl/line_timer.sv
`timescale 1ns/1ps
// line_timer: free-running clock-in-line and line-in-frame counters with
// an odd/even field flag. A restart request forces a fixed line of the
// odd field and the start of a line.
// Assumes: LINE_CLKS >= 2, 1 <= RESTART_LINE <= LINES/2.
module line_timer #(
    parameter int LINE_CLKS    = 64,
    parameter int LINES        = 525,
    parameter int RESTART_LINE = 6,
    parameter int LW           = 10,
    parameter int PW           = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [PW-1:0] pix,
    output logic [LW-1:0] line,
    output logic          field_odd
);
    localparam int            HALF      = LINES / 2;
    localparam logic [PW-1:0] PIX_LAST  = PW'(LINE_CLKS - 1);
    localparam logic [LW-1:0] LINE_LAST = LW'(LINES);
    localparam logic [LW-1:0] LINE_HALF = LW'(HALF);
    localparam logic [LW-1:0] LINE_RST  = LW'(RESTART_LINE);

    // Advance position; restart has priority over normal counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix       <= '0;
            line      <= LW'(1);
            field_odd <= 1'b1;
        end else if (restart) begin
            pix       <= '0;
            line      <= LINE_RST;
            field_odd <= 1'b1;
        end else if (pix == PIX_LAST) begin
            pix <= '0;
            if (line == LINE_LAST) begin
                line      <= LW'(1);
                field_odd <= 1'b1;
            end else begin
                line <= line + 1'b1;
                if (line == LINE_HALF)
                    field_odd <= 1'b0;
            end
        end else begin
            pix <= pix + 1'b1;
        end
    end

    // R6: line stays inside the frame
    a_r6_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (line >= LW'(1)) && (line <= LINE_LAST));

    // R6: a non-zero position is always one step past the previous one
    a_r6_pix_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (pix != '0) |-> (pix == $past(pix) + 1'b1));

    // R7: the toggled field flag agrees with the line number
    a_r7_field_matches_line: assert property (@(posedge clk) disable iff (!rst_n)
        field_odd == (line <= LINE_HALF));
endmodule

// File: rtl/expo_fsm.sv
`timescale 1ns/1ps
// expo_fsm: exposure sequence. Idle -> two flush strobes separated by a
// gap -> integration while the trigger is low -> one readout strobe.
// A trigger already high when the flush ends gives a one-cycle
// integration, then readout.
// Assumes: FLUSH_W, GAP_W, READ_W >= 1; CW holds the largest of them.
module expo_fsm
    import expo_pkg::*;
#(
    parameter int FLUSH_W = 8,
    parameter int GAP_W   = 4,
    parameter int READ_W  = 8,
    parameter int CW      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_lvl,
    input  logic trig_fell,
    output logic xfer,
    output logic integ,
    output logic flush_go,
    output logic read_go
);
    localparam logic [CW-1:0] FL_LD = CW'(FLUSH_W - 1);
    localparam logic [CW-1:0] GP_LD = CW'(GAP_W - 1);
    localparam logic [CW-1:0] RD_LD = CW'(READ_W - 1);

    seq_state_t       st_q, st_d;
    logic [CW-1:0]    tmr_q;
    logic             ld;
    logic [CW-1:0]    ld_val;
    logic             tmr_done;

    assign tmr_done = (tmr_q == '0);

    // Next-state and timer-load selection.
    always_comb begin
        st_d   = st_q;
        ld     = 1'b0;
        ld_val = '0;
        case (st_q)
            SQ_IDLE: if (trig_fell) begin
                st_d = SQ_FLUSH_A; ld = 1'b1; ld_val = FL_LD;
            end
            SQ_FLUSH_A: if (tmr_done) begin
                st_d = SQ_GAP; ld = 1'b1; ld_val = GP_LD;
            end
            SQ_GAP: if (tmr_done) begin
                st_d = SQ_FLUSH_B; ld = 1'b1; ld_val = FL_LD;
            end
            SQ_FLUSH_B: if (tmr_done) st_d = SQ_INTEG;
            SQ_INTEG: if (trig_lvl) begin
                st_d = SQ_READ; ld = 1'b1; ld_val = RD_LD;
            end
            SQ_READ: if (tmr_done) st_d = SQ_IDLE;
            default: st_d = SQ_IDLE;
        endcase
    end

    // State and down-counting phase timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            tmr_q <= '0;
        end else begin
            st_q  <= st_d;
            if (ld)
                tmr_q <= ld_val;
            else if (!tmr_done)
                tmr_q <= tmr_q - 1'b1;
        end
    end

    assign xfer     = (st_q == SQ_FLUSH_A) || (st_q == SQ_FLUSH_B) || (st_q == SQ_READ);
    assign integ    = (st_q == SQ_INTEG);
    assign flush_go = (st_q == SQ_IDLE) && (st_d == SQ_FLUSH_A);
    assign read_go  = (st_q != SQ_READ) && (st_d == SQ_READ);

    // R1: an accepted falling edge produces a strobe on the next cycle
    a_r1_flush_follows_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_IDLE && trig_fell) |=> xfer);

    // R3: integration ends only into a readout strobe
    a_r3_integ_to_readout: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(integ) |-> xfer);
endmodule

// File: rtl/video_gate.sv
`timescale 1ns/1ps
// video_gate: opens the frame and line enables for the single odd field
// that follows a readout; black elsewhere.
// Assumes: the line timer restarts in the odd field on readout.
module video_gate #(
    parameter int H_ACTIVE     = 48,
    parameter int ACTIVE_START = 20,
    parameter int LW           = 10,
    parameter int PW           = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          read_go,
    input  logic          flush_go,
    input  logic [PW-1:0] pix,
    input  logic [LW-1:0] line,
    input  logic          field_odd,
    output logic          frame_en,
    output logic          line_en,
    output logic          blank
);
    localparam logic [LW-1:0] FIRST_ACT = LW'(ACTIVE_START);
    localparam logic [PW-1:0] PIX_ACT   = PW'(H_ACTIVE);

    logic armed_q;

    // Arm on readout; disarm on a new flush or once the odd field ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (read_go)
            armed_q <= 1'b1;
        else if (flush_go || !field_odd)
            armed_q <= 1'b0;
    end

    assign frame_en = armed_q && field_odd && (line >= FIRST_ACT);
    assign line_en  = frame_en && (pix < PIX_ACT);
    assign blank    = ~line_en;

    // R8: the frame enable never opens before the first active line
    a_r8_frame_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_en) |-> (line == FIRST_ACT) && (pix == '0));
endmodule

// File: rtl/exposure_sequencer.sv
`timescale 1ns/1ps
// exposure_sequencer: top. Synchronises the trigger, runs the exposure
// sequence and the line timer, and gates one field of active video per
// exposure.
// Assumes: H_ACTIVE < LINE_CLKS, ACTIVE_START <= LINES/2.
module exposure_sequencer #(
    parameter int LINE_CLKS    = 64,
    parameter int H_ACTIVE     = 48,
    parameter int LINES        = 525,
    parameter int RESTART_LINE = 6,
    parameter int ACTIVE_START = 20,
    parameter int FLUSH_W      = 8,
    parameter int GAP_W        = 4,
    parameter int READ_W       = 8,
    localparam int LW          = $clog2(LINES + 1),
    localparam int PW          = $clog2(LINE_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_n,
    output logic          xfer_strb,
    output logic          integ_on,
    output logic [LW-1:0] line_no,
    output logic [PW-1:0] pix_no,
    output logic          field_odd,
    output logic          frame_en,
    output logic          line_en,
    output logic          blank
);
    localparam int W_MAX0 = (FLUSH_W > GAP_W) ? FLUSH_W : GAP_W;
    localparam int W_MAX  = (W_MAX0 > READ_W) ? W_MAX0 : READ_W;
    localparam int CW     = $clog2(W_MAX + 1);

    logic trig_lvl, trig_fell, flush_go, read_go;

    trig_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_n   (trig_n),
        .trig_lvl (trig_lvl),
        .trig_fell(trig_fell)
    );

    expo_fsm #(
        .FLUSH_W(FLUSH_W), .GAP_W(GAP_W), .READ_W(READ_W), .CW(CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_lvl (trig_lvl),
        .trig_fell(trig_fell),
        .xfer     (xfer_strb),
        .integ    (integ_on),
        .flush_go (flush_go),
        .read_go  (read_go)
    );

    line_timer #(
        .LINE_CLKS(LINE_CLKS), .LINES(LINES), .RESTART_LINE(RESTART_LINE),
        .LW(LW), .PW(PW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (read_go),
        .pix      (pix_no),
        .line     (line_no),
        .field_odd(field_odd)
    );

    video_gate #(
        .H_ACTIVE(H_ACTIVE), .ACTIVE_START(ACTIVE_START), .LW(LW), .PW(PW)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .read_go  (read_go),
        .flush_go (flush_go),
        .pix      (pix_no),
        .line     (line_no),
        .field_odd(field_odd),
        .frame_en (frame_en),
        .line_en  (line_en),
        .blank    (blank)
    );

    // R4: the readout strobe starts on the restart line of the odd field
    a_r4_restart_on_readout: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(xfer_strb) && $past(integ_on)) |->
            (line_no == LW'(RESTART_LINE)) && (pix_no == '0) && field_odd);

    // R9: no active video while the sensor integrates
    a_r9_no_enable_integ: assert property (@(posedge clk) disable iff (!rst_n)
        integ_on |-> !frame_en && blank);
endmodule

// File: tb/exposure_sequencer_test.sv
`timescale 1ns/1ps
module exposure_sequencer_test;
    localparam int LC = 16, HA = 12, NL = 525, RL = 6, AS = 20;
    localparam int FW = 4, GW = 3, RW = 5;
    localparam int HALF = NL / 2;

    logic clk = 1'b0, rst_n = 1'b0, trig_n = 1'b1;
    logic xfer_strb, integ_on, field_odd, frame_en, line_en, blank;
    logic [9:0] line_no;
    logic [3:0] pix_no;

    int checks = 0, errors = 0;
    bit done = 1'b0, mon_on = 1'b0, pend_expect = 1'b0;
    int n_trig = 0, n_read = 0, n_wrap = 0, n_abort = 0;

    always #2.5 clk = ~clk;

    exposure_sequencer #(
        .LINE_CLKS(LC), .H_ACTIVE(HA), .LINES(NL), .RESTART_LINE(RL),
        .ACTIVE_START(AS), .FLUSH_W(FW), .GAP_W(GW), .READ_W(RW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .xfer_strb(xfer_strb),
        .integ_on(integ_on), .line_no(line_no), .pix_no(pix_no),
        .field_odd(field_odd), .frame_en(frame_en), .line_en(line_en),
        .blank(blank)
    );

    function automatic int field_en_cycles();
        return (HALF - AS + 1) * HA;
    endfunction

    function automatic int next_pix(int p);
        return (p == LC - 1) ? 0 : p + 1;
    endfunction

    function automatic int next_line(int l, int p);
        if (p != LC - 1) return l;
        return (l == NL) ? 1 : l + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Cycle monitor: strobe shapes, counters and enable model.
    int pc = 0, hicnt = 0, lowcnt = 0, intcnt = 0, en_cnt = 0;
    bit armed_m = 1'b0, first = 1'b1;
    bit p_xfer = 1'b0, p_field = 1'b1;
    int p_line = 1, p_pix = 0;
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            bit restart_now;
            bit exp_frame, exp_line;
            restart_now = 1'b0;
            if (xfer_strb && !p_xfer) begin
                case (pc)
                    0: begin
                        if (armed_m) n_abort++;
                        armed_m = 1'b0;
                        pc = 1;
                    end
                    1: begin
                        chk(lowcnt == GW, "R2 gap", lowcnt, GW);
                        pc = 2;
                    end
                    2: begin
                        chk(intcnt == lowcnt, "R3 integ span", intcnt, lowcnt);
                        if (pend_expect) chk(lowcnt == 1, "R5 held readout", lowcnt, 1);
                        chk(line_no == RL && pix_no == 0 && field_odd, "R4 restart line",
                            int'(line_no), RL);
                        restart_now = 1'b1;
                        armed_m = 1'b1;
                        en_cnt = 0;
                        n_read++;
                        pc = 3;
                    end
                    default: chk(1'b0, "R4 extra strobe", pc, 0);
                endcase
                hicnt = 1;
            end else if (xfer_strb) begin
                hicnt++;
            end
            if (!xfer_strb) begin
                if (p_xfer) begin
                    chk(hicnt == ((pc == 3) ? RW : FW), (pc == 3) ? "R4 width" : "R2 width",
                        hicnt, (pc == 3) ? RW : FW);
                    if (pc == 3) pc = 0;
                    lowcnt = 0;
                    intcnt = 0;
                end
                lowcnt++;
                if (integ_on) intcnt++;
            end
            if (integ_on && !(pc == 2 && !xfer_strb))
                chk(1'b0, "R3 integ outside window", pc, 2);
            if (!first && !restart_now) begin
                chk(int'(pix_no) == next_pix(p_pix), "R6 pix", int'(pix_no), next_pix(p_pix));
                chk(int'(line_no) == next_line(p_line, p_pix), "R6 line",
                    int'(line_no), next_line(p_line, p_pix));
                if (p_line == NL && line_no == 1) n_wrap++;
            end
            chk(field_odd == (line_no <= HALF), "R7 field", field_odd, line_no <= HALF);
            if (armed_m && !field_odd) begin
                chk(en_cnt == field_en_cycles(), "R8 field count", en_cnt, field_en_cycles());
                armed_m = 1'b0;
            end
            exp_frame = armed_m && field_odd && (line_no >= AS);
            exp_line  = exp_frame && (pix_no < HA);
            chk(frame_en == exp_frame, "R8 frame_en", frame_en, exp_frame);
            chk(line_en == exp_line, "R8 line_en", line_en, exp_line);
            chk(blank == !line_en, "R9 blank", blank, !line_en);
            if (integ_on) chk(!frame_en, "R9 enable while integrating", frame_en, 0);
            if (line_en) en_cnt++;
            first = 1'b0;
        end
        p_xfer = xfer_strb; p_line = int'(line_no); p_pix = int'(pix_no); p_field = field_odd;
    end

    // Falling trigger with a strict latency check on the flush strobe.
    task automatic do_fall();
        trig_n = 1'b0;
        n_trig++;
        repeat (2) begin
            @(negedge clk);
            chk(!xfer_strb, "R1 early strobe", xfer_strb, 0);
        end
        @(negedge clk);
        chk(xfer_strb, "R1 flush latency", xfer_strb, 1);
    endtask

    // Rising trigger; when integration is under way check readout latency.
    task automatic do_rise(input bit timed);
        trig_n = 1'b1;
        if (timed) begin
            repeat (2) begin
                @(negedge clk);
                chk(integ_on && !xfer_strb, "R4 early readout", integ_on, 1);
            end
            @(negedge clk);
            chk(xfer_strb && !integ_on, "R4 readout latency", xfer_strb, 1);
        end
    endtask

    task automatic exposure(input int idle, input int low);
        repeat (idle) @(negedge clk);
        @(negedge clk);
        if (low >= 3) begin
            do_fall();
            repeat (low - 3) @(negedge clk);
        end else begin
            trig_n = 1'b0;
            n_trig++;
            repeat (low) @(negedge clk);
        end
        do_rise(low >= 40);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        chk(line_no == 1 && pix_no == 0 && field_odd, "R11 counters", int'(line_no), 1);
        chk(!xfer_strb && !integ_on, "R11 sequence", xfer_strb, 0);
        chk(!frame_en && !line_en && blank, "R11 video", blank, 1);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        // R6/R9: one full frame idle, counters wrap, video black
        repeat (9000) @(negedge clk);
        chk(n_wrap >= 1, "R6 wrap", n_wrap, 1);
        // directed: normal exposure
        exposure(10, 200);
        repeat (4400) @(negedge clk);
        // R5: trigger pulse shorter than the flush
        pend_expect = 1'b1;
        exposure(10, 2);
        repeat (4400) @(negedge clk);
        pend_expect = 1'b0;
        // integration longer than a frame
        exposure(10, 10000);
        repeat (4400) @(negedge clk);
        // R10: new trigger during the delivered field
        exposure(10, 100);
        repeat (2500) @(negedge clk);
        chk(frame_en, "R10 field open before abort", frame_en, 1);
        do_fall();
        chk(!frame_en, "R10 enable closed", frame_en, 0);
        n_trig = n_trig;
        repeat (297) @(negedge clk);
        do_rise(1'b1);
        repeat (4400) @(negedge clk);
        // constrained random exposures
        for (int i = 0; i < 6; i++) begin
            exposure(20 + int'($urandom % 980), 1 + int'($urandom % 2000));
            repeat (4400) @(negedge clk);
        end
        chk(n_read == n_trig, "R4 one readout per trigger", n_read, n_trig);
        chk(n_abort >= 1, "R10 abort seen", n_abort, 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule